// File: doc/BRIEF.md
# Multiplexed Address/Data External Bus Master

This block drives a 16-bit external memory bus in which the low sixteen address bits and the data share one set of pins. A CPU-side request (address, write data, byte or word size, direction) is turned into a fixed pin sequence. First an address phase, marked by an address-latch pulse. Then a one-cycle address hold. Then a read or write strobe. Then one recovery cycle, in which the requester gets a one-cycle `ready` pulse.

Writes use two strobes, one for each byte lane. The low-lane strobe covers AD[7:0] and the high-lane strobe covers AD[15:8]. Reads use a single read strobe and release the AD drivers while the external device answers. An optional extended-wait mode lets a slow device hold the strobe low through an active-low `wait_n` pin. A divided clock output is also provided. The clock output and the latch pulse can each be switched off to reduce noise.

All timing is counted in `clk` cycles. The length of the latch pulse is set by `ALE_CYC` and the base strobe width by `STB_CYC`. Both are parameters.

Top module: `mxbus_ctrl`

## Requirements
- R1: After a request is accepted, `ale` is high for exactly `ALE_CYC` cycles (when `ale_en`=1). During these cycles `ad_oe`=1 and `ad_out` equals addr[15:0].
- R2: In the cycle after `ale` falls, `ad_out` still carries addr[15:0] with `ad_oe`=1 and all strobes high. The strobe falls in the next cycle.
- R3: Without extension, the active strobe stays low for exactly `STB_CYC` cycles. All strobes are high at every other point of an access and while idle.
- R4: Read data is taken from `ad_in` in the last strobe-low cycle. A word read returns all 16 bits. A byte read returns lane addr[0] (0 = AD[7:0], 1 = AD[15:8]) zero-extended to 16 bits.
- R5: A word write lowers `wr_n` and `hwr_n` together and drives `wdata`. A byte write to an even address lowers only `wr_n`; one to an odd address lowers only `hwr_n`. A byte write drives wdata[7:0] on both lanes. Write data stays driven through the cycle after the strobe rises.
- R6: During a read, `ad_oe` is 0 for every cycle in which `rd_n` is low and for the cycle after `rd_n` rises.
- R7: `addr_hi` equals addr[23:16] of the current access throughout the access.
- R8: With `clkout_en`=1, `clk_out` toggles on every `clk` edge. With `clkout_en`=0 it is held low.
- R9: With `ale_en`=0, `ale` stays low and every other pin keeps the same cycle timing.
- R10: `ready` is high for exactly one cycle: the cycle after the strobe rises. `rdata` is valid in that cycle.
- R11: With `wait_mode`=1, `wait_n` is sampled at the end of the last base strobe cycle and of each added cycle. Each low sample adds one cycle. With `wait_mode`=0, or in earlier strobe cycles, `wait_n` has no effect.
- R12: While `rst` is high and right after it, `ale`=0, `ad_oe`=0, `ready`=0, `clk_out`=0 and all strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, held until `ready` |
| we | input | 1 | 1 = write, 0 = read |
| word | input | 1 | 1 = 16-bit access, 0 = byte |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write data (byte in bits 7:0) |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Read result |
| wait_mode | input | 1 | Enables the wait_n extension |
| ale_en | input | 1 | Enables the latch pulse |
| clkout_en | input | 1 | Enables the divided clock output |
| ad_out | output | DATA_W | Multiplexed address/data out |
| ad_oe | output | 1 | Drive enable for ad_out |
| ad_in | input | DATA_W | Multiplexed data in |
| addr_hi | output | ADDR_W-DATA_W | Upper address lines |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Low-lane write strobe, active low |
| hwr_n | output | 1 | High-lane write strobe, active low |
| wait_n | input | 1 | External wait, active low |
| clk_out | output | 1 | System clock divided by 2 |

## Verification
The bench drives `wait_n` randomly during the early strobe cycles and then holds it low for a chosen number of cycles from the last base cycle on. A controller that samples too early would stretch the strobe by the wrong amount, and one that ignores `wait_mode` would stretch accesses that should not be stretched. It feeds a fresh random `ad_in` value in every strobe cycle, so capturing one cycle early or late returns the wrong word. Odd and even byte writes and reads check lane steering, where a swapped strobe or a wrong read lane shows at once. `ad_oe` is checked in the recovery cycle of reads to catch drivers turned back on while the device may still be driving.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ALE_HI,
    PH_ALE_LO,
    PH_STB,
    PH_REC
  } phase_t;
endpackage

// File: rtl/mxbus_seq.sv
module mxbus_seq import mxbus_pkg::*; #(
  parameter int ALE_CYC = 2,
  parameter int STB_CYC = 4
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   req,
  input  logic   wait_mode,
  input  logic   wait_n,
  output phase_t phase_q,
  output phase_t phase_d,
  output logic   accept
);
  localparam int MAXC = (ALE_CYC > STB_CYC) ? ALE_CYC : STB_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    accept  = 1'b0;
    case (phase_q)
      PH_IDLE: if (req) begin
        accept  = 1'b1;
        phase_d = PH_ALE_HI;
        cnt_d   = '0;
      end
      PH_ALE_HI: if (cnt_q == CW'(ALE_CYC - 1)) begin
        phase_d = PH_ALE_LO;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      PH_ALE_LO: begin
        phase_d = PH_STB;
        cnt_d   = '0;
      end
      PH_STB: if (cnt_q != CW'(STB_CYC - 1)) begin
        cnt_d = cnt_q + 1'b1;
      end else if (!(wait_mode && !wait_n)) begin
        phase_d = PH_REC;
      end
      PH_REC: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  // R2: strobe phase is entered only from the address-hold cycle
  a_r2_strobe_after_hold: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_STB && $past(phase_q) != PH_STB) |-> $past(phase_q) == PH_ALE_LO);

  // R11: a strobe cycle beyond the base width needs a low wait sample in wait mode
  a_r11_extend_only_on_wait: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_STB && $past(phase_q) == PH_STB && $past(cnt_q) == CW'(STB_CYC - 1))
      |-> $past(wait_mode && !wait_n));
endmodule

// File: rtl/mxbus_lane.sv
module mxbus_lane import mxbus_pkg::*; #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  phase_t                   phase_q,
  input  phase_t                   phase_d,
  input  logic                     accept,
  input  logic                     we,
  input  logic                     word,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     ale_en,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     hwr_n,
  output logic                     ready,
  output logic [DATA_W-1:0]        rdata
);
  localparam int LANE_W = DATA_W / 2;

  logic              we_q, word_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              we_n, word_n;
  logic [ADDR_W-1:0] addr_n;
  logic [DATA_W-1:0] wdata_n, wlane;

  logic [DATA_W-1:0] ad_d;
  logic ad_oe_d, ale_d, rd_n_d, wr_n_d, hwr_n_d, stb_d, addr_ph;

  assign we_n    = accept ? we    : we_q;
  assign word_n  = accept ? word  : word_q;
  assign addr_n  = accept ? addr  : addr_q;
  assign wdata_n = accept ? wdata : wdata_q;
  assign wlane   = word_n ? wdata_n : {wdata_n[LANE_W-1:0], wdata_n[LANE_W-1:0]};

  always_comb begin
    addr_ph = (phase_d == PH_ALE_HI) || (phase_d == PH_ALE_LO);
    stb_d   = (phase_d == PH_STB);
    ale_d   = ale_en && (phase_d == PH_ALE_HI);
    rd_n_d  = !(stb_d && !we_n);
    wr_n_d  = !(stb_d && we_n && (word_n || !addr_n[0]));
    hwr_n_d = !(stb_d && we_n && (word_n ||  addr_n[0]));
    if (addr_ph) begin
      ad_d    = addr_n[DATA_W-1:0];
      ad_oe_d = 1'b1;
    end else if ((stb_d || phase_d == PH_REC) && we_n) begin
      ad_d    = wlane;
      ad_oe_d = 1'b1;
    end else begin
      ad_d    = '0;
      ad_oe_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q    <= 1'b0;
      word_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      ad_out  <= '0;
      ad_oe   <= 1'b0;
      addr_hi <= '0;
      ale     <= 1'b0;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
      hwr_n   <= 1'b1;
      ready   <= 1'b0;
      rdata   <= '0;
    end else begin
      we_q    <= we_n;
      word_q  <= word_n;
      addr_q  <= addr_n;
      wdata_q <= wdata_n;
      ad_out  <= ad_d;
      ad_oe   <= ad_oe_d;
      addr_hi <= addr_n[ADDR_W-1:DATA_W];
      ale     <= ale_d;
      rd_n    <= rd_n_d;
      wr_n    <= wr_n_d;
      hwr_n   <= hwr_n_d;
      ready   <= (phase_d == PH_REC);
      if (phase_q == PH_STB && phase_d == PH_REC && !we_q) begin
        if (word_q)
          rdata <= ad_in;
        else if (addr_q[0])
          rdata <= {{LANE_W{1'b0}}, ad_in[DATA_W-1:LANE_W]};
        else
          rdata <= {{LANE_W{1'b0}}, ad_in[LANE_W-1:0]};
      end
    end
  end

  // R6: drivers stay off while the read strobe is low
  a_r6_oe_off_in_read: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ad_oe);
  // R6: drivers still off in the cycle after the read strobe rises
  a_r6_oe_off_after_read: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_n) |-> !ad_oe);
  // R5: both write strobes together only for a word access
  a_r5_dual_strobe_word: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && !hwr_n) |-> word_q);
  // R10: ready is a single-cycle pulse
  a_r10_ready_single: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);
  // R7: upper address constant while a strobe is low
  a_r7_addr_hi_stable: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n || !hwr_n) |-> $stable(addr_hi));
endmodule

// File: rtl/mxbus_clkdiv.sv
module mxbus_clkdiv (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic clk_out
);
  always_ff @(posedge clk) begin
    if (rst || !en) clk_out <= 1'b0;
    else            clk_out <= ~clk_out;
  end

  // R8: output held low while disabled
  a_r8_low_when_off: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> !clk_out);
endmodule

// File: rtl/mxbus_ctrl.sv
module mxbus_ctrl import mxbus_pkg::*; #(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 16,
  parameter int ALE_CYC = 2,
  parameter int STB_CYC = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req,
  input  logic                     we,
  input  logic                     word,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic                     ready,
  output logic [DATA_W-1:0]        rdata,
  input  logic                     wait_mode,
  input  logic                     ale_en,
  input  logic                     clkout_en,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     hwr_n,
  input  logic                     wait_n,
  output logic                     clk_out
);
  phase_t phase_q, phase_d;
  logic   accept;

  mxbus_seq #(.ALE_CYC(ALE_CYC), .STB_CYC(STB_CYC)) u_seq (
    .clk(clk), .rst(rst), .req(req), .wait_mode(wait_mode), .wait_n(wait_n),
    .phase_q(phase_q), .phase_d(phase_d), .accept(accept)
  );

  mxbus_lane #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lane (
    .clk(clk), .rst(rst), .phase_q(phase_q), .phase_d(phase_d), .accept(accept),
    .we(we), .word(word), .addr(addr), .wdata(wdata), .ale_en(ale_en),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .addr_hi(addr_hi),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .hwr_n(hwr_n),
    .ready(ready), .rdata(rdata)
  );

  mxbus_clkdiv u_clkdiv (
    .clk(clk), .rst(rst), .en(clkout_en), .clk_out(clk_out)
  );

  // R3: at most one kind of strobe per access (read never overlaps writes)
  a_r3_no_mixed_strobe: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> (wr_n && hwr_n));
  // R1: latch pulse only while the address is driven
  a_r1_ale_with_addr: assert property (@(posedge clk) disable iff (rst)
    ale |-> ad_oe);
endmodule

// File: tb/mxbus_ctrl_tb.sv
module mxbus_ctrl_tb;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int ALE_CYC = 2;
  localparam int STB_CYC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, we = 1'b0, word = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, ad_in = '0;
  logic wait_mode = 1'b0, ale_en = 1'b1, clkout_en = 1'b1, wait_n = 1'b1;
  logic ready, ad_oe, ale, rd_n, wr_n, hwr_n, clk_out;
  logic [DW-1:0] rdata, ad_out;
  logic [AW-DW-1:0] addr_hi;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  mxbus_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ALE_CYC(ALE_CYC), .STB_CYC(STB_CYC)) u_dut (
    .clk(clk), .rst(rst), .req(req), .we(we), .word(word), .addr(addr),
    .wdata(wdata), .ready(ready), .rdata(rdata), .wait_mode(wait_mode),
    .ale_en(ale_en), .clkout_en(clkout_en), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(ad_in), .addr_hi(addr_hi), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .hwr_n(hwr_n), .wait_n(wait_n), .clk_out(clk_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_wlane(input bit wd, input logic [DW-1:0] d);
    return wd ? d : {d[7:0], d[7:0]};
  endfunction

  function automatic logic [DW-1:0] exp_rd(input bit wd, input bit odd, input logic [DW-1:0] v);
    if (wd) return v;
    return odd ? {8'h00, v[15:8]} : {8'h00, v[7:0]};
  endfunction

  task automatic access(input bit w, input bit wd, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input bit wm, input int k, input bit ae);
    int len;
    logic [DW-1:0] lastin;
    bit done;
    lastin = '0;
    done = 1'b0;
    len = STB_CYC + (wm ? k : 0);
    @(negedge clk);
    req = 1'b1; we = w; word = wd; addr = a; wdata = d; wait_mode = wm; ale_en = ae;
    wait_n = 1'b1;
    for (int c = 1; c < 60 && !done; c++) begin
      @(negedge clk);
      chk(addr_hi == a[23:16], "R7 addr_hi", {24'h0, addr_hi}, {24'h0, a[23:16]});
      if (c <= ALE_CYC) begin
        chk(ale == ae, ae ? "R1 ale high" : "R9 ale held low", {31'h0, ale}, {31'h0, ae});
        chk(ad_oe && ad_out == a[15:0], "R1 address on AD", {15'h0, ad_oe, ad_out}, {16'h1, a[15:0]});
        chk(rd_n && wr_n && hwr_n, "R3 strobes high in address phase", {29'h0, rd_n, wr_n, hwr_n}, 32'h7);
      end else if (c == ALE_CYC + 1) begin
        chk(!ale, "R2 ale low in hold", {31'h0, ale}, 32'h0);
        chk(ad_oe && ad_out == a[15:0], "R2 address held", {15'h0, ad_oe, ad_out}, {16'h1, a[15:0]});
        chk(rd_n && wr_n && hwr_n, "R2 strobes high in hold", {29'h0, rd_n, wr_n, hwr_n}, 32'h7);
      end else if (c <= ALE_CYC + 1 + len) begin
        int j;
        logic [2:0] es;
        j = c - ALE_CYC - 1;
        es = {w, !(w && (wd || !a[0])), !(w && (wd || a[0]))};
        chk({rd_n, wr_n, hwr_n} == es, w ? "R5 write strobe lanes" : "R3 read strobe",
            {29'h0, rd_n, wr_n, hwr_n}, {29'h0, es});
        chk(!ready, "R10 ready low during strobe", {31'h0, ready}, 32'h0);
        if (w)
          chk(ad_oe && ad_out == exp_wlane(wd, d), "R5 write data", {15'h0, ad_oe, ad_out}, {16'h1, exp_wlane(wd, d)});
        else
          chk(!ad_oe, "R6 oe off in read strobe", {31'h0, ad_oe}, 32'h0);
        ad_in = DW'($urandom);
        lastin = ad_in;
        if (j < STB_CYC) wait_n = $urandom_range(0, 1) != 0;
        else             wait_n = !(j < STB_CYC + k);
        if (j == STB_CYC && k == 0) wait_n = 1'b1;
      end else begin
        wait_n = 1'b1;
        chk(ready, "R10 ready in recovery", {31'h0, ready}, 32'h1);
        chk(rd_n && wr_n && hwr_n, "R3 strobe width / R11 wait", {29'h0, rd_n, wr_n, hwr_n}, 32'h7);
        if (w) begin
          chk(ad_oe && ad_out == exp_wlane(wd, d), "R5 write data hold", {15'h0, ad_oe, ad_out}, {16'h1, exp_wlane(wd, d)});
        end else begin
          chk(!ad_oe, "R6 oe off after read", {31'h0, ad_oe}, 32'h0);
          chk(rdata == exp_rd(wd, a[0], lastin), "R4 read data", {16'h0, rdata}, {16'h0, exp_rd(wd, a[0], lastin)});
        end
        req = 1'b0;
        done = 1'b1;
      end
    end
    chk(done, "R10 access completed", {31'h0, done}, 32'h1);
    @(negedge clk);
    chk(!ready && !ad_oe, "R10 single ready pulse", {30'h0, ready, ad_oe}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired R10 actual=hang expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(!ale && !ad_oe && !ready && !clk_out && rd_n && wr_n && hwr_n, "R12 reset state",
        {25'h0, ale, ad_oe, ready, clk_out, rd_n, wr_n, hwr_n}, 32'h7);
    rst = 1'b0;
    @(negedge clk);
    chk(!ale && !ad_oe && !ready && rd_n && wr_n && hwr_n, "R12 idle after reset",
        {26'h0, ale, ad_oe, ready, rd_n, wr_n, hwr_n}, 32'h7);

    // R8: divided clock toggles, then held low
    begin
      logic prev;
      prev = clk_out;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        chk(clk_out != prev, "R8 clk_out toggles", {31'h0, clk_out}, {31'h0, ~prev});
        prev = clk_out;
      end
      clkout_en = 1'b0;
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chk(!clk_out, "R8 clk_out held low", {31'h0, clk_out}, 32'h0);
      end
      clkout_en = 1'b1;
    end

    // Directed lane and phase cases (R1-R7, R10)
    access(1, 1, 24'h12_3456, 16'hBEEF, 0, 0, 1);
    access(1, 0, 24'hA0_0010, 16'h00C3, 0, 0, 1);
    access(1, 0, 24'hA0_0011, 16'h005A, 0, 0, 1);
    access(0, 1, 24'h7F_FFFE, 16'h0000, 0, 0, 1);
    access(0, 0, 24'h01_0002, 16'h0000, 0, 0, 1);
    access(0, 0, 24'h01_0003, 16'h0000, 0, 0, 1);
    // R11: wait extension and its gating
    access(0, 1, 24'h20_0000, 16'h0000, 1, 0, 1);
    access(0, 1, 24'h20_0100, 16'h0000, 1, 1, 1);
    access(1, 1, 24'h20_0200, 16'h1357, 1, 3, 1);
    access(0, 0, 24'h20_0301, 16'h0000, 0, 3, 1);
    // R9: latch pulse disabled
    access(1, 0, 24'h33_0045, 16'h0077, 0, 0, 0);
    access(0, 1, 24'h33_0046, 16'h0000, 1, 2, 0);

    // Random mix
    for (int i = 0; i < 40; i++) begin
      access($urandom_range(0, 1) != 0, $urandom_range(0, 1) != 0, AW'($urandom),
             DW'($urandom), $urandom_range(0, 1) != 0, $urandom_range(0, 4),
             $urandom_range(0, 3) != 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule